// File: doc/BRIEF.md
# Vertical Row and Raster Sequencer

This block is the vertical half of a character-cell display timing generator. On every end-of-scanline tick it advances a raster-line counter inside the current character row. When the raster counter reaches the programmed maximum, the row counter advances. After the last programmed row, an optional block of extra adjust scanlines pads the frame before the next one begins. The block also keeps a flag that marks the lower border, which is the region below the displayed rows, and it emits a one-cycle pulse when a new frame begins.

Five timing variants are selectable at run time, numbered 0 to 4. They differ in two places. The first is how the row counter behaves during the adjust scanlines and which counter measures them. The second is whether the border compare follows the displayed-rows setting continuously or only where a new row begins. Variant codes 5 to 7 behave as variant 0. All configuration inputs are plain levels that software may change at any time. The tick is a single-cycle strobe. There is no stream interface, so no handshake applies.

Top module: `vrow_timing`

## Requirements
- R1: After reset, `row`, `ras` and `frame_start` are 0. `vborder` is 0 when `cfg_vdisp` is non-zero.
- R2: A tick at `ras` below `cfg_maxras` increments `ras`. A tick at `ras == cfg_maxras` clears `ras` and increments `row`. Without a tick, `row` and `ras` hold. Results appear one clock after the edge that samples the tick.
- R3: When `cfg_adjust` is 0, a tick at `ras == cfg_maxras` and `row == cfg_vtotal` returns both counters to 0 and raises `frame_start` for exactly one clock. The frame always lasts (`cfg_vtotal`+1)*(`cfg_maxras`+1)+`cfg_adjust` ticks.
- R4: Variants 3 and 4 keep `row` equal to `cfg_vtotal` through the adjust scanlines. During those scanlines, `ras` counts 0 to `cfg_adjust`-1 without wrapping at `cfg_maxras`.
- R5: Variant 0 steps `row` once to `cfg_vtotal`+1 on entering the adjust scanlines and holds it there. During those scanlines, `ras` counts 0 to `cfg_adjust`-1 without wrapping at `cfg_maxras`.
- R6: Variants 1 and 2 measure the adjust scanlines with a separate counter. During those scanlines, `ras` keeps wrapping at `cfg_maxras`. `row` starts at `cfg_vtotal`+1 and increments on each wrap.
- R7: In variants 0, 1 and 2, `vborder` rises in the same cycle that `row` equals `cfg_vdisp`, including when `cfg_vdisp` is rewritten in the middle of a row. It then stays high until the frame restarts.
- R8: In variant 1, a `cfg_vdisp` of 0 raises `vborder` at once at any row. Variants 0 and 2 do not do this.
- R9: In variants 3 and 4, `vborder` is set only by the tick that starts a row whose number equals `cfg_vdisp`, one clock after that tick. A change of `cfg_vdisp` in the middle of a row has no effect until the next row start.
- R10: At frame restart `vborder` clears, unless `cfg_vdisp` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_end | input | 1 | One-cycle strobe at the end of each scanline |
| cfg_vtotal | input | 7 | Index of the last character row |
| cfg_adjust | input | 5 | Number of extra adjust scanlines; 0 skips them |
| cfg_vdisp | input | 7 | Number of displayed character rows |
| cfg_maxras | input | 5 | Index of the last scanline within a row |
| variant | input | 3 | Timing variant, 0 to 4; 5 to 7 act as 0 |
| row | output | 7 | Character-row counter |
| ras | output | 5 | Raster address within the row |
| vborder | output | 1 | Lower-border flag |
| frame_start | output | 1 | One-cycle pulse when a new frame begins |

## Verification
`row`, `ras` and `frame_start` pass through a single register stage. The bench therefore raises the tick at a falling edge and reads these outputs at the next falling edge, after exactly one rising edge. An extra idle falling edge confirms that the values hold. In variants 0 to 2, the border reacts combinationally to `cfg_vdisp`, so it is read 1 ns after the setting is changed at a falling edge, before any rising edge. In variants 3 and 4, the border is read at the falling edge after the row-starting tick, and it is also confirmed unchanged after ticks that stay inside the row. The sweep compares every tick against a closed-form position within the frame.

// File: rtl/vrow_pkg.sv
package vrow_pkg;

  localparam int VAR_W = 3;

  // Per-variant behaviour switches
  typedef struct packed {
    logic cmp_live;     // border compare follows cfg_vdisp continuously
    logic zero_blank;   // displayed-rows value of 0 blanks at once
    logic step_entry;   // row steps once when adjust scanlines begin
    logic own_adj_ctr;  // adjust scanlines counted by a dedicated counter
  } vflags_t;

  function automatic vflags_t decode_variant(input logic [VAR_W-1:0] v);
    vflags_t f;
    case (v)
      3'd1:    f = '{cmp_live: 1'b1, zero_blank: 1'b1, step_entry: 1'b1, own_adj_ctr: 1'b1};
      3'd2:    f = '{cmp_live: 1'b1, zero_blank: 1'b0, step_entry: 1'b1, own_adj_ctr: 1'b1};
      3'd3,
      3'd4:    f = '{cmp_live: 1'b0, zero_blank: 1'b0, step_entry: 1'b0, own_adj_ctr: 1'b0};
      default: f = '{cmp_live: 1'b1, zero_blank: 1'b0, step_entry: 1'b1, own_adj_ctr: 1'b0};
    endcase
    return f;
  endfunction

endpackage

// File: rtl/vrow_count.sv
module vrow_count #(
  parameter int ROW_W = 7,
  parameter int RAS_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_end,
  input  logic [ROW_W-1:0] vtotal,
  input  logic [RAS_W-1:0] maxras,
  input  logic [RAS_W-1:0] adj_lines,
  input  logic             step_entry,
  input  logic             own_adj_ctr,
  output logic [ROW_W-1:0] row,
  output logic [RAS_W-1:0] ras,
  output logic [ROW_W-1:0] next_row,
  output logic             row_start,
  output logic             restart,
  output logic             frame_start
);

  localparam int ACW = RAS_W + 1;

  logic [ROW_W-1:0] row_q, row_n;
  logic [RAS_W-1:0] ras_q, ras_n;
  logic [RAS_W-1:0] adjc_q, adjc_n;
  logic             adj_q, adj_n;
  logic             fs_q;

  logic             ras_wrap, last_row, adj_zero, adj_done, enter_adj;
  logic [RAS_W-1:0] adj_idx;

  assign ras_wrap = (ras_q == maxras);
  assign last_row = (row_q == vtotal);
  assign adj_zero = (adj_lines == '0);
  assign adj_idx  = own_adj_ctr ? adjc_q : ras_q;
  // Compare with one extra bit so a shrinking adjust length still ends the phase
  assign adj_done = ({1'b0, adj_idx} + ACW'(1)) >= {1'b0, adj_lines};

  assign restart   = line_end && (adj_q ? adj_done : (ras_wrap && last_row && adj_zero));
  assign enter_adj = line_end && !adj_q && ras_wrap && last_row && !adj_zero;
  assign row_start = restart || (line_end && !adj_q && ras_wrap && !last_row);

  always_comb begin
    row_n  = row_q;
    ras_n  = ras_q;
    adjc_n = adjc_q;
    adj_n  = adj_q;
    if (restart) begin
      row_n  = '0;
      ras_n  = '0;
      adjc_n = '0;
      adj_n  = 1'b0;
    end else if (line_end) begin
      if (!adj_q) begin
        if (ras_wrap) begin
          ras_n = '0;
          if (enter_adj) begin
            adj_n  = 1'b1;
            adjc_n = '0;
            if (step_entry) row_n = row_q + ROW_W'(1);
          end else begin
            row_n = row_q + ROW_W'(1);
          end
        end else begin
          ras_n = ras_q + RAS_W'(1);
        end
      end else if (own_adj_ctr) begin
        adjc_n = adjc_q + RAS_W'(1);
        if (ras_wrap) begin
          ras_n = '0;
          row_n = row_q + ROW_W'(1);
        end else begin
          ras_n = ras_q + RAS_W'(1);
        end
      end else begin
        ras_n = ras_q + RAS_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q  <= '0;
      ras_q  <= '0;
      adjc_q <= '0;
      adj_q  <= 1'b0;
      fs_q   <= 1'b0;
    end else begin
      row_q  <= row_n;
      ras_q  <= ras_n;
      adjc_q <= adjc_n;
      adj_q  <= adj_n;
      fs_q   <= restart;
    end
  end

  assign row         = row_q;
  assign ras         = ras_q;
  assign next_row    = row_n;
  assign frame_start = fs_q;

endmodule

// File: rtl/vrow_border.sv
module vrow_border #(
  parameter int ROW_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmp_live,
  input  logic             zero_blank,
  input  logic [ROW_W-1:0] row,
  input  logic [ROW_W-1:0] next_row,
  input  logic             row_start,
  input  logic             restart,
  input  logic [ROW_W-1:0] vdisp,
  output logic             vborder
);

  logic bdr_q;
  logic hit_now;

  // Live compare: current row against the setting as it stands this cycle
  assign hit_now = cmp_live && ((row == vdisp) || (zero_blank && (vdisp == '0)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bdr_q <= 1'b0;
    end else if (cmp_live) begin
      if (restart)      bdr_q <= 1'b0;
      else if (hit_now) bdr_q <= 1'b1;
    end else if (row_start) begin
      // Sampled compare: only the row about to begin is tested
      bdr_q <= (bdr_q && !restart) || (next_row == vdisp);
    end
  end

  assign vborder = bdr_q || hit_now;

endmodule

// File: rtl/vrow_timing.sv
module vrow_timing #(
  parameter int ROW_W = 7,
  parameter int RAS_W = 5
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      line_end,
  input  logic [ROW_W-1:0]          cfg_vtotal,
  input  logic [RAS_W-1:0]          cfg_adjust,
  input  logic [ROW_W-1:0]          cfg_vdisp,
  input  logic [RAS_W-1:0]          cfg_maxras,
  input  logic [vrow_pkg::VAR_W-1:0] variant,
  output logic [ROW_W-1:0]          row,
  output logic [RAS_W-1:0]          ras,
  output logic                      vborder,
  output logic                      frame_start
);

  import vrow_pkg::*;

  vflags_t          fl;
  logic [ROW_W-1:0] nxt_row;
  logic             row_start, restart;

  assign fl = decode_variant(variant);

  vrow_count #(.ROW_W(ROW_W), .RAS_W(RAS_W)) u_count (
    .clk         (clk),
    .rst_n       (rst_n),
    .line_end    (line_end),
    .vtotal      (cfg_vtotal),
    .maxras      (cfg_maxras),
    .adj_lines   (cfg_adjust),
    .step_entry  (fl.step_entry),
    .own_adj_ctr (fl.own_adj_ctr),
    .row         (row),
    .ras         (ras),
    .next_row    (nxt_row),
    .row_start   (row_start),
    .restart     (restart),
    .frame_start (frame_start)
  );

  vrow_border #(.ROW_W(ROW_W)) u_border (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmp_live   (fl.cmp_live),
    .zero_blank (fl.zero_blank),
    .row        (row),
    .next_row   (nxt_row),
    .row_start  (row_start),
    .restart    (restart),
    .vdisp      (cfg_vdisp),
    .vborder    (vborder)
  );

endmodule

// File: rtl/vrow_timing_sva.sv
module vrow_timing_sva #(
  parameter int ROW_W = 7,
  parameter int RAS_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             line_end,
  input logic [2:0]       variant,
  input logic [ROW_W-1:0] cfg_vdisp,
  input logic [ROW_W-1:0] row,
  input logic [RAS_W-1:0] ras,
  input logic             vborder,
  input logic             frame_start
);

  logic late;
  assign late = (variant == 3'd3) || (variant == 3'd4);

  a_r2_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !line_end |=> ($stable(row) && $stable(ras)));

  a_r3_frame_at_origin: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> (row == '0 && ras == '0));

  a_r3_frame_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !line_end |=> !frame_start);

  a_r7_live_border: assert property (@(posedge clk) disable iff (!rst_n)
    (!late && row == cfg_vdisp) |-> vborder);

  a_r9_sampled_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (late && !line_end) |=> (!late || $stable(vborder)));

endmodule

bind vrow_timing vrow_timing_sva #(.ROW_W(ROW_W), .RAS_W(RAS_W)) u_sva (
  .clk         (clk),
  .rst_n       (rst_n),
  .line_end    (line_end),
  .variant     (variant),
  .cfg_vdisp   (cfg_vdisp),
  .row         (row),
  .ras         (ras),
  .vborder     (vborder),
  .frame_start (frame_start)
);

// File: tb/vrow_timing_test.sv
`timescale 1ns/1ps
module vrow_timing_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       line_end = 1'b0;
  logic [6:0] cfg_vtotal = '0;
  logic [4:0] cfg_adjust = '0;
  logic [6:0] cfg_vdisp = 7'd2;
  logic [4:0] cfg_maxras = '0;
  logic [2:0] variant = '0;
  logic [6:0] row;
  logic [4:0] ras;
  logic       vborder, frame_start;

  int n_tests = 0;
  int n_fail  = 0;

  always #4 clk = ~clk;

  vrow_timing uut (
    .clk(clk), .rst_n(rst_n), .line_end(line_end),
    .cfg_vtotal(cfg_vtotal), .cfg_adjust(cfg_adjust), .cfg_vdisp(cfg_vdisp),
    .cfg_maxras(cfg_maxras), .variant(variant),
    .row(row), .ras(ras), .vborder(vborder), .frame_start(frame_start)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic setup(input int v, input int r4, input int r5, input int r6, input int r9);
    @(negedge clk);
    rst_n = 1'b0;
    line_end = 1'b0;
    variant = 3'(v); cfg_vtotal = 7'(r4); cfg_adjust = 5'(r5);
    cfg_vdisp = 7'(r6); cfg_maxras = 5'(r9);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // Tick raised at a falling edge, outputs read at the next falling edge
  task automatic tick();
    line_end = 1'b1;
    @(negedge clk);
    line_end = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  // Closed-form position within the frame for scanline index k
  task automatic model(input int v, input int r4, input int r9, input int k,
                       output int er, output int ea, output string tag);
    int n = (r4 + 1) * (r9 + 1);
    if (k < n) begin
      er = k / (r9 + 1); ea = k % (r9 + 1); tag = "R2";
    end else if (v == 3 || v == 4) begin
      er = r4; ea = k - n; tag = "R4";
    end else if (v == 0) begin
      er = r4 + 1; ea = k - n; tag = "R5";
    end else begin
      er = r4 + 1 + (k - n) / (r9 + 1); ea = (k - n) % (r9 + 1); tag = "R6";
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run stalled, got 0 expected 1");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int er, ea, len, k, prow, pras;
    string tag, btag;
    bit seen;

    // R1: reset state
    setup(0, 4, 0, 2, 3);
    chk("R1 row", row, 0);
    chk("R1 ras", ras, 0);
    chk("R1 frame_start", frame_start, 0);
    chk("R1 vborder", vborder, 0);

    // Near-exhaustive sweep over a small configuration space
    for (int v = 0; v < 5; v++)
      for (int r4 = 0; r4 < 3; r4++)
        for (int r9 = 0; r9 < 3; r9++)
          for (int ai = 0; ai < 3; ai++)
            for (int r6 = 0; r6 < 3; r6 += 2) begin
              int r5 = (ai == 2) ? 3 : ai;
              setup(v, r4, r5, r6, r9);
              len = (r4 + 1) * (r9 + 1) + r5;
              k = 0;
              seen = 0;
              for (int t = 0; t < 3 * len; t++) begin
                tick();
                k = (k + 1) % len;
                if (k == 0) seen = 1;
                model(v, r4, r9, k, er, ea, tag);
                chk({tag, " row"}, row, er);
                chk({tag, " ras"}, ras, ea);
                chk("R3 frame_start", frame_start, (k == 0) ? 1 : 0);
                if (seen) begin
                  if (k == 0)                  btag = "R10";
                  else if (v == 3 || v == 4)   btag = "R9";
                  else if (v == 1 && r6 == 0)  btag = "R8";
                  else                         btag = "R7";
                  chk({btag, " vborder"}, vborder, (er >= r6) ? 1 : 0);
                end
                if (t % 4 == 1) begin
                  prow = row; pras = ras;
                  @(negedge clk);
                  chk("R2 hold row", row, prow);
                  chk("R2 hold ras", ras, pras);
                  chk("R3 single pulse", frame_start, 0);
                end
              end
            end

    // R7: live compare reacts to a mid-row rewrite
    setup(0, 4, 0, 4, 3);
    ticks(9);
    chk("R7 before rewrite", vborder, 0);
    cfg_vdisp = 7'd2;
    #1 chk("R7 mid-row rewrite", vborder, 1);

    // R9: sampled compare waits for the next row start
    setup(3, 4, 0, 4, 3);
    ticks(9);
    cfg_vdisp = 7'd3;
    #1 chk("R9 mid-row rewrite ignored", vborder, 0);
    @(negedge clk);
    ticks(2);
    chk("R9 still inside row", vborder, 0);
    tick();
    chk("R9 row start row", row, 3);
    chk("R9 set at row start", vborder, 1);

    // R8: zero displayed rows blanks at once on variant 1 only
    setup(1, 4, 0, 4, 3);
    ticks(9);
    cfg_vdisp = 7'd0;
    #1 chk("R8 variant1 zero", vborder, 1);
    setup(2, 4, 0, 4, 3);
    ticks(9);
    cfg_vdisp = 7'd0;
    #1 chk("R8 variant2 zero", vborder, 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule